// File: doc/BRIEF.md
# Paged ISA Window Bridge

This block connects an 8-bit host bus of the 6502 kind to an ISA-style expansion bus. It does this through a 256-byte window that sits in one host I/O page. Two control bytes, which live outside the window, set the following:

- whether the window is enabled;
- whether it reaches ISA memory space or ISA I/O space;
- the upper byte (the page) of the ISA address;
- whether reads are 8-bit or latched 16-bit.

A host access inside the window becomes a single ISA bus cycle. Its address joins the page value with the low byte of the host address.

Reads need ISA data, so they hold the host with a ready line that stays low until the ISA cycle has finished. In 16-bit mode the ISA read captures both bytes. The stalled host read returns the low byte. The next host read at the same offset returns the captured high byte and does not touch the ISA bus. Writes are posted: each one produces one 8-bit ISA write cycle while the host carries on. The ISA strobe lasts a set minimum number of clocks and stretches while the ISA channel-ready input is low.

Host protocol: the host holds `host_req`, `host_rw`, `host_addr` and `host_wdata` steady. The access completes on the rising edge where `host_req` and `host_rdy` are both high.

Top module: `isa_win_bridge`

## Requirements
- R1: When config bit 0 (enable) is 1, every access whose host address has upper byte `WIN_PAGE` raises `host_claim` in the same cycle. When enable is 0, a window access raises no claim, keeps `host_rdy` high and starts no ISA cycle.
- R2: The ISA address is `{page, host_addr[7:0]}`. It is captured when the cycle starts and stays stable while the strobe is low, even if the page register is rewritten during the cycle.
- R3: When config bit 1 is 1, reads use `isa_ior_n` and writes use `isa_iow_n`. When it is 0, reads use `isa_memr_n` and writes use `isa_memw_n`. At most one of the four strobes is low at any time.
- R4: A strobe stays low for exactly `STROBE_MIN` clocks if `isa_iochrdy` is high. If `isa_iochrdy` is low for the first W strobe clocks, the strobe lasts max(`STROBE_MIN`, W+1) clocks.
- R5: In 8-bit mode (config bit 2 = 0), a window read keeps `host_rdy` low for 1 + strobe-length cycles. It runs one ISA read with `isa_wide` low and returns `isa_din[7:0]`.
- R6: In 16-bit mode (config bit 2 = 1), a window read stalls in the same way with `isa_wide` high. It returns `isa_din[7:0]` and latches `isa_din[15:8]`.
- R7: After a 16-bit read, the next window read at the same offset completes with no stall and no ISA cycle, and returns the latched high byte. The read after that, at the same offset, starts a new ISA cycle.
- R8: A window write finds the engine idle and completes with no stall. It then produces one 8-bit ISA write that drives `host_wdata` on `isa_dout` with `isa_dout_en` high during the write strobe only. This holds in 16-bit mode too.
- R9: A window access that arrives while an ISA cycle is in progress keeps `host_rdy` low until the engine is idle. It then proceeds as usual.
- R10: The config byte at `CTRL_ADDR` (bits 2:0 = wide, io, enable; other bits read 0) and the page byte at `CTRL_ADDR+1` are written and read back without stall. They are never claimed as window accesses.
- R11: After reset all strobes are high, `host_rdy` is high, and both control bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access valid |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 16 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdy | output | 1 | Host ready; low stalls the access |
| host_claim | output | 1 | Window decoded; overrides other devices on that page |
| isa_addr | output | PAGE_W+8 | ISA address |
| isa_ior_n | output | 1 | I/O read strobe |
| isa_iow_n | output | 1 | I/O write strobe |
| isa_memr_n | output | 1 | Memory read strobe |
| isa_memw_n | output | 1 | Memory write strobe |
| isa_wide | output | 1 | Current read is 16-bit |
| isa_dout | output | 8 | ISA write data |
| isa_dout_en | output | 1 | ISA write data drive enable |
| isa_din | input | 16 | ISA read data |
| isa_iochrdy | input | 1 | ISA channel ready; low stretches the strobe |

## Verification
Two things can land in the same cycle.

The first is a posted ISA write that is still strobing when the host issues its next window read. The bench provokes this by issuing the read on the cycle right after the write completes. It judges the result by the exact stall count: strobe remainder, plus the request cycle, plus the new strobe. It also checks that the read data still comes from the read address.

The second is a page-register write that lands while an earlier write's strobe is in progress. The bench checks that the captured ISA address keeps the old page.

// File: rtl/isa_win_pkg.sv
`timescale 1ns/1ps
package isa_win_pkg;

    typedef struct packed {
        logic wide;
        logic io;
        logic en;
    } win_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_STROBE = 2'd1,
        ENG_DONE   = 2'd2
    } eng_state_e;

    function automatic logic [7:0] cfg_byte(input win_cfg_t c);
        return {5'b0, c.wide, c.io, c.en};
    endfunction

endpackage

// File: rtl/isa_win_decode.sv
`timescale 1ns/1ps
module isa_win_decode #(
    parameter logic [7:0]  WIN_PAGE  = 8'hDE,
    parameter logic [15:0] CTRL_ADDR = 16'hDF00
) (
    input  logic        host_req,
    input  logic [15:0] host_addr,
    input  logic        win_en,
    output logic        win_hit,
    output logic        cfg_hit,
    output logic        page_hit
);
    localparam logic [15:0] PAGE_REG_ADDR = 16'(CTRL_ADDR + 16'd1);

    always_comb begin
        win_hit  = host_req && win_en && (host_addr[15:8] == WIN_PAGE);
        cfg_hit  = host_req && (host_addr == CTRL_ADDR);
        page_hit = host_req && (host_addr == PAGE_REG_ADDR);
    end
endmodule

// File: rtl/isa_win_regs.sv
`timescale 1ns/1ps
module isa_win_regs
    import isa_win_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_page,
    input  logic [7:0]        wdata,
    output win_cfg_t          cfg,
    output logic [PAGE_W-1:0] page
);
    typedef struct packed {
        win_cfg_t          cfg;
        logic [PAGE_W-1:0] page;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_cfg)  d.cfg  = win_cfg_t'(wdata[2:0]);
        if (wr_page) d.page = wdata[PAGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg  = q.cfg;
    assign page = q.page;
endmodule

// File: rtl/isa_win_engine.sv
`timescale 1ns/1ps
module isa_win_engine
    import isa_win_pkg::*;
#(
    parameter int ISA_AW     = 16,
    parameter int STROBE_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic              start_io,
    input  logic              start_wide,
    input  logic [ISA_AW-1:0] start_addr,
    input  logic [7:0]        start_wdata,
    input  logic              iochrdy,
    input  logic [15:0]       din,
    output logic              busy,
    output logic              done,
    output logic [ISA_AW-1:0] isa_addr,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              wide,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [7:0]        lo_byte,
    output logic [7:0]        hi_byte
);
    localparam int CNT_W = (STROBE_MIN > 1) ? $clog2(STROBE_MIN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_MIN - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ISA_AW-1:0] addr;
        logic              rd;
        logic              io;
        logic              wide;
        logic [7:0]        wdata;
        logic [7:0]        lo;
        logic [7:0]        hi;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ENG_IDLE: begin
                if (start) begin
                    d.st    = ENG_STROBE;
                    d.cnt   = '0;
                    d.addr  = start_addr;
                    d.rd    = start_rd;
                    d.io    = start_io;
                    d.wide  = start_rd && start_wide;
                    d.wdata = start_wdata;
                end
            end
            ENG_STROBE: begin
                if (q.cnt != CNT_LAST) d.cnt = q.cnt + 1'b1;
                if ((q.cnt == CNT_LAST) && iochrdy) begin
                    if (q.rd) begin
                        d.lo = din[7:0];
                        d.hi = q.wide ? din[15:8] : 8'h00;
                        d.st = ENG_DONE;
                    end else begin
                        d.st = ENG_IDLE;
                    end
                end
            end
            ENG_DONE: d.st = ENG_IDLE;
            default:  d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, default: '0};
        else        q <= d;
    end

    logic stb;
    assign stb      = (q.st == ENG_STROBE);
    assign busy     = stb;
    assign done     = (q.st == ENG_DONE);
    assign isa_addr = q.addr;
    assign ior_n    = !(stb &&  q.io &&  q.rd);
    assign iow_n    = !(stb &&  q.io && !q.rd);
    assign memr_n   = !(stb && !q.io &&  q.rd);
    assign memw_n   = !(stb && !q.io && !q.rd);
    assign wide     = stb && q.wide;
    assign dout     = q.wdata;
    assign dout_en  = stb && !q.rd;
    assign lo_byte  = q.lo;
    assign hi_byte  = q.hi;
endmodule

// File: rtl/isa_win_bridge.sv
`timescale 1ns/1ps
module isa_win_bridge
    import isa_win_pkg::*;
#(
    parameter logic [7:0]  WIN_PAGE   = 8'hDE,
    parameter logic [15:0] CTRL_ADDR  = 16'hDF00,
    parameter int          PAGE_W     = 8,
    parameter int          STROBE_MIN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_rw,
    input  logic [15:0]           host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic                  host_rdy,
    output logic                  host_claim,
    output logic [PAGE_W+7:0]     isa_addr,
    output logic                  isa_ior_n,
    output logic                  isa_iow_n,
    output logic                  isa_memr_n,
    output logic                  isa_memw_n,
    output logic                  isa_wide,
    output logic [7:0]            isa_dout,
    output logic                  isa_dout_en,
    input  logic [15:0]           isa_din,
    input  logic                  isa_iochrdy
);
    localparam int OFF_W  = 8;
    localparam int ISA_AW = PAGE_W + OFF_W;

    win_cfg_t          cfg;
    logic [PAGE_W-1:0] page;
    logic              win_hit, cfg_hit, page_hit;
    logic              eng_busy, eng_done, eng_start;
    logic [7:0]        eng_lo, eng_hi;

    typedef struct packed {
        logic             hi_valid;
        logic [OFF_W-1:0] hi_off;
    } top_t;

    top_t q, d;

    logic win_rd, win_wr, hi_take, eng_idle, ctrl_wr_cfg, ctrl_wr_page;

    isa_win_decode #(.WIN_PAGE(WIN_PAGE), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .host_req (host_req),
        .host_addr(host_addr),
        .win_en   (cfg.en),
        .win_hit  (win_hit),
        .cfg_hit  (cfg_hit),
        .page_hit (page_hit)
    );

    isa_win_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (ctrl_wr_cfg),
        .wr_page(ctrl_wr_page),
        .wdata  (host_wdata),
        .cfg    (cfg),
        .page   (page)
    );

    isa_win_engine #(.ISA_AW(ISA_AW), .STROBE_MIN(STROBE_MIN)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .start_rd   (host_rw),
        .start_io   (cfg.io),
        .start_wide (cfg.wide),
        .start_addr ({page, host_addr[OFF_W-1:0]}),
        .start_wdata(host_wdata),
        .iochrdy    (isa_iochrdy),
        .din        (isa_din),
        .busy       (eng_busy),
        .done       (eng_done),
        .isa_addr   (isa_addr),
        .ior_n      (isa_ior_n),
        .iow_n      (isa_iow_n),
        .memr_n     (isa_memr_n),
        .memw_n     (isa_memw_n),
        .wide       (isa_wide),
        .dout       (isa_dout),
        .dout_en    (isa_dout_en),
        .lo_byte    (eng_lo),
        .hi_byte    (eng_hi)
    );

    always_comb begin
        eng_idle     = !eng_busy && !eng_done;
        win_rd       = win_hit && host_rw;
        win_wr       = win_hit && !host_rw;
        hi_take      = win_rd && q.hi_valid && (q.hi_off == host_addr[OFF_W-1:0]);
        eng_start    = eng_idle && ((win_rd && !hi_take) || win_wr);
        host_rdy     = !((win_rd && !hi_take && !eng_done) || (win_wr && !eng_idle));
        host_claim   = win_hit;
        ctrl_wr_cfg  = cfg_hit  && !host_rw;
        ctrl_wr_page = page_hit && !host_rw;

        host_rdata = 8'h00;
        if (cfg_hit && host_rw)       host_rdata = cfg_byte(cfg);
        else if (page_hit && host_rw) host_rdata = 8'(page);
        else if (hi_take)             host_rdata = eng_hi;
        else if (win_rd && eng_done)  host_rdata = eng_lo;

        d = q;
        if (eng_start || hi_take || (win_wr && host_rdy) || ctrl_wr_cfg || ctrl_wr_page)
            d.hi_valid = 1'b0;
        if (win_rd && eng_done && cfg.wide) begin
            d.hi_valid = 1'b1;
            d.hi_off   = host_addr[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

module isa_win_bridge_chk #(
    parameter int ISA_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_rw,
    input logic              host_claim,
    input logic              host_rdy,
    input logic [ISA_AW-1:0] isa_addr,
    input logic              isa_ior_n,
    input logic              isa_iow_n,
    input logic              isa_memr_n,
    input logic              isa_memw_n,
    input logic              isa_dout_en,
    input logic              isa_iochrdy
);
    logic stb;
    assign stb = !(isa_ior_n && isa_iow_n && isa_memr_n && isa_memw_n);

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~isa_ior_n, ~isa_iow_n, ~isa_memr_n, ~isa_memw_n}) <= 1);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && $past(stb)) |-> $stable(isa_addr));

    // R4
    wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !isa_iochrdy) |=> stb);

    // R9
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_rw && host_claim && stb) |-> !host_rdy);

    // R8
    dout_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_dout_en |-> (!isa_iow_n || !isa_memw_n));
endmodule

bind isa_win_bridge isa_win_bridge_chk #(.ISA_AW(PAGE_W + 8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_rw    (host_rw),
    .host_claim (host_claim),
    .host_rdy   (host_rdy),
    .isa_addr   (isa_addr),
    .isa_ior_n  (isa_ior_n),
    .isa_iow_n  (isa_iow_n),
    .isa_memr_n (isa_memr_n),
    .isa_memw_n (isa_memw_n),
    .isa_dout_en(isa_dout_en),
    .isa_iochrdy(isa_iochrdy)
);

// File: tb/sim_isa_win_bridge.sv
`timescale 1ns/1ps
module sim_isa_win_bridge;
    localparam int          SMIN  = 3;
    localparam logic [15:0] CTRL  = 16'hDF00;
    localparam logic [7:0]  WPAGE = 8'hDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_rw = 1'b1;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rdy, host_claim;
    logic [15:0] isa_addr;
    logic        isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n, isa_wide, isa_dout_en;
    logic [7:0]  isa_dout;
    logic [15:0] isa_din;
    logic        isa_iochrdy = 1'b1;

    always #2.5 clk = ~clk;

    isa_win_bridge #(.WIN_PAGE(WPAGE), .CTRL_ADDR(CTRL), .PAGE_W(8), .STROBE_MIN(SMIN)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rw(host_rw),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .host_claim(host_claim), .isa_addr(isa_addr),
        .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n), .isa_memr_n(isa_memr_n),
        .isa_memw_n(isa_memw_n), .isa_wide(isa_wide), .isa_dout(isa_dout),
        .isa_dout_en(isa_dout_en), .isa_din(isa_din), .isa_iochrdy(isa_iochrdy)
    );

    // ISA responder: data is a function of the address
    assign isa_din = {isa_addr[7:0] + 8'h11, isa_addr[15:8] ^ isa_addr[7:0] ^ 8'h3C};

    int          ws = 0, wl = 0;
    int          isa_cnt = 0, rec_len = 0;
    logic [15:0] rec_addr;
    logic [3:0]  rec_kind;
    logic [7:0]  rec_data;
    logic        rec_wide, rec_doe, prev_stb = 1'b0;

    always @(negedge clk) begin
        logic stb_now;
        int   wv;
        stb_now = !(isa_ior_n && isa_iow_n && isa_memr_n && isa_memw_n);
        if (stb_now) begin
            if (!prev_stb) begin
                isa_cnt++;
                rec_len  = 1;
                rec_addr = isa_addr;
                rec_kind = {~isa_ior_n, ~isa_iow_n, ~isa_memr_n, ~isa_memw_n};
                rec_data = isa_dout;
                rec_wide = isa_wide;
                rec_doe  = isa_dout_en;
                wv = ws;
            end else begin
                rec_len++;
                wv = (wl > 0) ? wl - 1 : 0;
            end
            wl = wv;
            isa_iochrdy = (wv == 0);
        end else begin
            isa_iochrdy = 1'b1;
        end
        prev_stb = stb_now;
    end

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hacc(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                        output logic [7:0] rd, output int stall, output logic claim);
        host_addr = a; host_rw = rw; host_wdata = wd; host_req = 1'b1;
        #1;
        claim = host_claim;
        stall = 0;
        while (!host_rdy && stall < 200) begin
            stall++;
            @(negedge clk); #1;
        end
        rd = host_rdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        host_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_lo(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] pick_page(input int i);
        case (i) 0: return 8'h00; 1: return 8'h03; 2: return 8'h7F; default: return 8'hFF; endcase
    endfunction

    function automatic logic [7:0] pick_off(input int i);
        case (i) 0: return 8'h00; 1: return 8'h40; 2: return 8'hA5; default: return 8'hFF; endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int st, c0, len;
        logic cl;
        logic [15:0] ea;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(host_rdy === 1'b1, "R11 rdy", host_rdy, 1);
        chk({isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n} === 4'hF, "R11 strobes",
            {isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n}, 4'hF);
        hacc(CTRL, 1'b1, 8'h00, rd, st, cl);
        chk(rd === 8'h00, "R11 cfg", rd, 0);
        hacc(CTRL + 16'd1, 1'b1, 8'h00, rd, st, cl);
        chk(rd === 8'h00, "R11 page", rd, 0);

        // R10 readback, unused bits read 0, no stall
        hacc(CTRL, 1'b0, 8'hFA, rd, st, cl);
        chk(st == 0, "R10 wr stall", st, 0);
        hacc(CTRL, 1'b1, 8'h00, rd, st, cl);
        chk(rd === 8'h02 && !cl, "R10 cfg rb", rd, 8'h02);
        hacc(CTRL + 16'd1, 1'b0, 8'h5C, rd, st, cl);
        hacc(CTRL + 16'd1, 1'b1, 8'h00, rd, st, cl);
        chk(rd === 8'h5C, "R10 page rb", rd, 8'h5C);

        // R1 disabled window: no claim, no stall, no ISA cycle
        c0 = isa_cnt;
        hacc({WPAGE, 8'h10}, 1'b1, 8'h00, rd, st, cl);
        idle(SMIN + 3);
        chk(!cl && st == 0 && isa_cnt == c0, "R1 disabled", isa_cnt - c0, 0);

        // Sweep: space, width, page, offset, wait states
        for (int sp = 0; sp < 2; sp++)
        for (int wd = 0; wd < 2; wd++)
        for (int pi = 0; pi < 4; pi++)
        for (int oi = 0; oi < 4; oi++)
        for (int wi = 0; wi < 2; wi++) begin
            ws  = wi * 3;
            len = (SMIN > ws + 1) ? SMIN : ws + 1;
            hacc(CTRL, 1'b0, {5'b0, wd[0], sp[0], 1'b1}, rd, st, cl);
            hacc(CTRL + 16'd1, 1'b0, pick_page(pi), rd, st, cl);
            ea = {pick_page(pi), pick_off(oi)};

            // R1 other page not claimed
            hacc({8'hDD, pick_off(oi)}, 1'b1, 8'h00, rd, st, cl);
            chk(!cl, "R1 other page", cl, 0);

            // Read (R5 / R6)
            c0 = isa_cnt;
            hacc({WPAGE, pick_off(oi)}, 1'b1, 8'h00, rd, st, cl);
            chk(cl, "R1 claim", cl, 1);
            chk(st == 1 + len, wd ? "R6 stall" : "R5 stall", st, 1 + len);
            chk(rd === exp_lo(ea), wd ? "R6 lo data" : "R5 data", rd, exp_lo(ea));
            chk(isa_cnt == c0 + 1, "R5 one cycle", isa_cnt - c0, 1);
            chk(rec_addr === ea, "R2 addr", rec_addr, ea);
            chk(rec_kind === (sp ? 4'b1000 : 4'b0010), "R3 read strobe", rec_kind, sp ? 8 : 2);
            chk(rec_len == len, "R4 length", rec_len, len);
            chk(rec_wide === wd[0], "R6 wide", rec_wide, wd);

            if (wd) begin
                // R7 high byte, then a fresh cycle
                hacc({WPAGE, pick_off(oi)}, 1'b1, 8'h00, rd, st, cl);
                chk(st == 0 && isa_cnt == c0 + 1, "R7 no cycle", st, 0);
                chk(rd === 8'(pick_off(oi) + 8'h11), "R7 hi data", rd, 8'(pick_off(oi) + 8'h11));
                hacc({WPAGE, pick_off(oi)}, 1'b1, 8'h00, rd, st, cl);
                chk(st == 1 + len && isa_cnt == c0 + 2, "R7 consumed", st, 1 + len);
            end

            // Write (R8)
            c0 = isa_cnt;
            hacc({WPAGE, pick_off(oi)}, 1'b0, pick_off(oi) ^ pick_page(pi) ^ 8'h96, rd, st, cl);
            chk(st == 0, "R8 no stall", st, 0);
            idle(len + 2);
            chk(isa_cnt == c0 + 1, "R8 one cycle", isa_cnt - c0, 1);
            chk(rec_addr === ea, "R2 wr addr", rec_addr, ea);
            chk(rec_kind === (sp ? 4'b0100 : 4'b0001), "R3 write strobe", rec_kind, sp ? 4 : 1);
            chk(rec_data === (pick_off(oi) ^ pick_page(pi) ^ 8'h96) && rec_doe && !rec_wide,
                "R8 data", rec_data, pick_off(oi) ^ pick_page(pi) ^ 8'h96);
            chk(rec_len == len, "R4 wr length", rec_len, len);
        end

        // R9 back-to-back: write then read at once
        ws = 0;
        hacc(CTRL, 1'b0, 8'h03, rd, st, cl);
        hacc(CTRL + 16'd1, 1'b0, 8'h03, rd, st, cl);
        hacc({WPAGE, 8'h40}, 1'b0, 8'h77, rd, st, cl);
        hacc({WPAGE, 8'h41}, 1'b1, 8'h00, rd, st, cl);
        chk(st == 2 * SMIN + 1, "R9 stall", st, 2 * SMIN + 1);
        chk(rd === exp_lo(16'h0341), "R9 data", rd, exp_lo(16'h0341));
        idle(2);

        // R2 page rewrite during an in-flight write
        c0 = isa_cnt;
        hacc({WPAGE, 8'h22}, 1'b0, 8'h5A, rd, st, cl);
        hacc(CTRL + 16'd1, 1'b0, 8'h99, rd, st, cl);
        chk(st == 0, "R10 ctrl while busy", st, 0);
        idle(SMIN + 2);
        chk(rec_addr === 16'h0322 && isa_cnt == c0 + 1, "R2 page held", rec_addr, 16'h0322);
        hacc({WPAGE, 8'h22}, 1'b1, 8'h00, rd, st, cl);
        chk(rd === exp_lo(16'h9922) && rec_addr === 16'h9922, "R2 new page", rec_addr, 16'h9922);

        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule